// File: doc/BRIEF.md
# Element-Width Reinterpret Cast Unit

This unit takes one vector register value laid out at a source element width and produces the register value that holds the same bytes at a destination element width. The result is the value that would appear if the source were written to memory at its own width and read back at the new width. Casting sixteen bytes to halfwords joins each pair of memory-adjacent bytes into one halfword. Casting the other way splits each element into its memory-ordered pieces.

The register file is split into VLEN/SLEN sections. An element of width SEW that fits inside a section is placed round-robin across the sections, so adjacent memory elements sit in different sections. The cast therefore cannot be a copy. It gathers the source bytes into memory order using the source-width placement, then scatters them using the destination-width placement. Bytes move between sections on the way. With a single section, or with equal widths, the permutation reduces to a copy.

A caller presents the operands with a one-cycle start. The unit registers the result and raises done on the following cycle.

Top module: `sew_cast_unit`

## Requirements
- R1: While rst_ni is low, done_o is 0 and result_o is all zeros.
- R2: done_o is 1 in the cycle after each cycle in which start_i is sampled high, and 0 in the cycle after a cycle in which start_i is sampled low.
- R3: result_o changes only on a clock edge at which start_i is high. Otherwise it keeps its value.
- R4: The width codes on src_sew_i and dst_sew_i are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Memory order is little-endian: memory byte m is byte (m mod E) of element (m div E), where E is the element size in bytes.
- R5: When an element of E bytes is no wider than SLEN and SLEN < VLEN, element i is held at register byte (i mod NCH)*SLEN/8 + (i div NCH)*E, with NCH = VLEN/SLEN. Byte k of the element is at that offset plus k, and register byte b is bits 8b+7..8b.
- R6: An element wider than SLEN is held in memory order, so register byte b is memory byte b.
- R7: result_o, taken after a start, equals the source value mapped to memory order with the source-width layout and then mapped into the destination-width layout.
- R8: When src_sew_i equals dst_sew_i, result_o equals src_vec_i.
- R9: When SLEN equals VLEN, result_o equals src_vec_i for every pair of widths.
- R10: A cast from 32-bit to 64-bit elements with SLEN=32 returns the memory-order image of the 32-bit vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a cast with the operands presented in this cycle |
| src_vec_i | input | VLEN | Source register value |
| src_sew_i | input | 2 | Source element width code |
| dst_sew_i | input | 2 | Destination element width code |
| done_o | output | 1 | Result valid, one cycle after start |
| result_o | output | VLEN | Registered cast result |

## Verification
Two functions can fall in the same cycle: the done pulse and result of one cast, and the capture of the next start. The bench provokes this by holding start high for two consecutive cycles with different operands and width pairs. At the middle sample it checks that done is high and that result holds the first cast. One cycle later it checks that done is still high and that result has moved to the second cast, with no cycle of the first value repeated.

// File: rtl/cast_pkg.sv
package cast_pkg;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  localparam int NUM_SEW = 4;

  // register byte holding memory byte m for element bytes eb
  function automatic int reg_of_mem(int m, int eb, int sb, int nch);
    int i;
    int k;
    if (eb > sb || nch == 1) return m;
    i = m / eb;
    k = m % eb;
    return (i % nch) * sb + (i / nch) * eb + k;
  endfunction

  // memory byte held in register byte r for element bytes eb
  function automatic int mem_of_reg(int r, int eb, int sb, int nch);
    int c;
    int off;
    if (eb > sb || nch == 1) return r;
    c   = r / sb;
    off = r % sb;
    return ((off / eb) * nch + c) * eb + (off % eb);
  endfunction

endpackage

// File: rtl/cast_perm.sv
module cast_perm #(
  parameter int VLEN   = 128,
  parameter int SLEN   = 32,
  parameter bit TO_MEM = 1'b1
) (
  input  logic [VLEN-1:0] vec_i,
  input  logic [1:0]      sew_i,
  output logic [VLEN-1:0] vec_o
);
  import cast_pkg::*;

  localparam int VB  = VLEN / 8;
  localparam int SB  = SLEN / 8;
  localparam int NCH = VLEN / SLEN;

  logic [VLEN-1:0] cand [NUM_SEW];

  for (genvar q = 0; q < NUM_SEW; q++) begin : g_sew
    localparam int EB = 1 << q;
    for (genvar b = 0; b < VB; b++) begin : g_byte
      // gather form: output byte b pulls from SRC
      localparam int SRC = TO_MEM ? reg_of_mem(b, EB, SB, NCH)
                                  : mem_of_reg(b, EB, SB, NCH);
      assign cand[q][b*8 +: 8] = vec_i[SRC*8 +: 8];
    end
  end

  always_comb vec_o = cand[sew_i];

endmodule

// File: rtl/cast_ctrl.sv
module cast_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic done_o
);

  logic done_q;

  assign load_o = start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= start_i;
  end

  assign done_o = done_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R2

endmodule

// File: rtl/sew_cast_unit.sv
module sew_cast_unit #(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VLEN-1:0] src_vec_i,
  input  logic [1:0]      src_sew_i,
  input  logic [1:0]      dst_sew_i,
  output logic            done_o,
  output logic [VLEN-1:0] result_o
);

  localparam int NCH = VLEN / SLEN;

  logic [VLEN-1:0] mem_img;
  logic [VLEN-1:0] dst_img;
  logic [VLEN-1:0] result_q;
  logic            load;

  cast_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .done_o (done_o)
  );

  // undo source-width placement
  cast_perm #(.VLEN(VLEN), .SLEN(SLEN), .TO_MEM(1'b1)) u_gather (
    .vec_i(src_vec_i),
    .sew_i(src_sew_i),
    .vec_o(mem_img)
  );

  // apply destination-width placement
  cast_perm #(.VLEN(VLEN), .SLEN(SLEN), .TO_MEM(1'b0)) u_scatter (
    .vec_i(mem_img),
    .sew_i(dst_sew_i),
    .vec_o(dst_img)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (load) result_q <= dst_img;
  end

  assign result_o = result_q;

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o)); // R3
  AST_SAME_SEW_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && src_sew_i == dst_sew_i) |=> result_o == $past(src_vec_i)); // R8
  AST_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $countones(result_o) == $past($countones(src_vec_i))); // R7

  if (NCH == 1) begin : g_flat_chk
    AST_FLAT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> result_o == $past(src_vec_i)); // R9
  end

endmodule

// File: tb/sew_cast_unit_test.sv
module sew_cast_unit_test;

  localparam int VLEN = 128;
  localparam int VB   = VLEN / 8;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [VLEN-1:0] src;
  logic [1:0]      ssew;
  logic [1:0]      dsew;
  logic            done;
  logic [VLEN-1:0] res;
  logic            done_f;
  logic [VLEN-1:0] res_f;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  sew_cast_unit #(.VLEN(VLEN), .SLEN(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_vec_i(src),
    .src_sew_i(ssew), .dst_sew_i(dsew), .done_o(done), .result_o(res)
  );

  sew_cast_unit #(.VLEN(VLEN), .SLEN(VLEN)) uut_flat (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_vec_i(src),
    .src_sew_i(ssew), .dst_sew_i(dsew), .done_o(done_f), .result_o(res_f)
  );

  // element-wise reference: register layout -> memory order
  function automatic logic [VLEN-1:0] to_mem(input logic [VLEN-1:0] v,
                                             input int code, input int slen);
    logic [VLEN-1:0] m;
    int e   = 1 << code;
    int sb  = slen / 8;
    int nch = VLEN / slen;
    m = '0;
    for (int i = 0; i < VB / e; i++) begin
      int base = (e > sb) ? i * e : (i % nch) * sb + (i / nch) * e;
      for (int k = 0; k < e; k++) m[(i*e+k)*8 +: 8] = v[(base+k)*8 +: 8];
    end
    return m;
  endfunction

  function automatic logic [VLEN-1:0] from_mem(input logic [VLEN-1:0] m,
                                               input int code, input int slen);
    logic [VLEN-1:0] v;
    int e   = 1 << code;
    int sb  = slen / 8;
    int nch = VLEN / slen;
    v = '0;
    for (int i = 0; i < VB / e; i++) begin
      int base = (e > sb) ? i * e : (i % nch) * sb + (i / nch) * e;
      for (int k = 0; k < e; k++) v[(base+k)*8 +: 8] = m[(i*e+k)*8 +: 8];
    end
    return v;
  endfunction

  function automatic logic [VLEN-1:0] ref_cast(input logic [VLEN-1:0] v,
                                               input int sc, input int dc, input int slen);
    return from_mem(to_mem(v, sc, slen), dc, slen);
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cast: drive at negedge, sample at following negedge
  task automatic run_cast(input logic [VLEN-1:0] v, input int sc, input int dc,
                          input string req, input logic [VLEN-1:0] exp);
    @(negedge clk);
    start = 1'b1; src = v; ssew = 2'(sc); dsew = 2'(dc);
    @(negedge clk);
    start = 1'b0;
    chk_bit("R2 done", done, 1'b1);
    chk_vec(req, res, exp);
  endtask

  initial begin
    logic [VLEN-1:0] v, prev;
    void'($urandom(32'h5EED_0C45));
    rst_n = 1'b0; start = 1'b0; src = '0; ssew = '0; dsew = '0;
    repeat (3) @(negedge clk);
    chk_bit("R1 done reset", done, 1'b0);
    chk_vec("R1 result reset", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R2 idle done", done, 1'b0);

    // R4 R5: 16 -> 32, halfword q holds A000+q
    for (int q = 0; q < 8; q++) v[q*16 +: 16] = 16'hA000 + 16'(q);
    run_cast(v, 1, 2, "R4 R5 16to32",
             128'hA007A005_A003A001_A006A004_A002A000);
    @(negedge clk);
    chk_bit("R2 pulse ends", done, 1'b0);
    chk_vec("R3 hold", res, 128'hA007A005_A003A001_A006A004_A002A000);

    // R6: 64 -> 8, byte m = m
    for (int m = 0; m < VB; m++) v[m*8 +: 8] = 8'(m);
    run_cast(v, 3, 0, "R6 64to8", 128'h0F0B0703_0E0A0602_0D090501_0C080400);

    // R10: 32 -> 64 is memory image of words
    v = 128'h33221100_77665544_BBAA9988_FFEEDDCC;
    run_cast(v, 2, 3, "R10 32to64", v);
    run_cast(v, 3, 2, "R10 64to32", v);

    // R8 same width
    for (int c = 0; c < 4; c++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      run_cast(v, c, c, "R8 same sew", v);
    end

    // back-to-back starts
    @(negedge clk);
    v = {$urandom, $urandom, $urandom, $urandom};
    prev = v;
    start = 1'b1; src = v; ssew = 2'd0; dsew = 2'd1;
    @(negedge clk);
    v = {$urandom, $urandom, $urandom, $urandom};
    src = v; ssew = 2'd2; dsew = 2'd0;
    chk_bit("R2 b2b first done", done, 1'b1);
    chk_vec("R7 b2b first", res, ref_cast(prev, 0, 1, 32));
    @(negedge clk);
    start = 1'b0;
    chk_bit("R2 b2b second done", done, 1'b1);
    chk_vec("R7 b2b second", res, ref_cast(v, 2, 0, 32));
    @(negedge clk);
    chk_bit("R2 b2b end", done, 1'b0);

    // random pairs, both layouts
    for (int n = 0; n < 300; n++) begin
      int sc = int'($urandom_range(3, 0));
      int dc = int'($urandom_range(3, 0));
      v = {$urandom, $urandom, $urandom, $urandom};
      run_cast(v, sc, dc, "R7 random", ref_cast(v, sc, dc, 32));
      chk_vec("R9 flat copy", res_f, v);
      if (n % 50 == 0) begin
        prev = res;
        src = ~v;
        repeat (2) @(negedge clk);
        chk_vec("R3 idle hold", res, prev);
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule